// File: doc/BRIEF.md
# Protocol Discovery Enumerator

This block finds out which protocols a message mailbox can carry. On a start pulse it first asks the request engine to abort, so the mailbox begins from a clean state. It then sends a chain of discovery requests through that engine. Every request asks about one 8-bit index. Every answer names one supported protocol, as a vendor ID and a type, together with the index to ask about next. The pairs go into a small table, one slot after another, until an answer points back to index zero. The block then reports done. A failed abort, a failed exchange, a malformed answer or a full table ends the walk with an error instead.

A combinational query port checks a vendor/type pair against the cached table and reports a hit. The discovery protocol itself always counts as supported. The same port also screens a task before it is sent: the task is accepted only if its pair hits, its request payload is a whole number of dwords and its response buffer holds at least one dword.

Top module: `proto_enum`

## Requirements
- R1: After reset, busy, done, error, abort_req and req_valid are 0 and entry_count is 0.
- R2: A start pulse in an idle, done or failed state raises abort_req from the next cycle until abort_done is seen. If abort_ok is 0 at that point the block goes to error and sends no request.
- R3: A discovery request has req_vid = 0x0001, req_type = 0, req_len_dw = 1 and req_payload = {24'b0, index}. The first index after a good abort is 0. req_valid and req_payload hold steady until req_ready is seen.
- R4: A good response has rsp_ok = 1, rsp_len_dw = 1, vendor ID in rsp_data[15:0], type in [23:16] and next index in [31:24]. A non-zero next index is used as the index of the following request. A zero next index ends the walk with done = 1.
- R5: Each good response's pair is stored in the next free table slot, in the order found. entry_count gives the number stored, and a query for any stored pair gives q_hit = 1.
- R6: A response with rsp_ok = 0 or rsp_len_dw other than 1 sets error and stops the walk: no further request is issued and error stays set until the next start.
- R7: A good response that arrives while the table already holds DEPTH entries sets error, stores nothing and stops the walk.
- R8: A query for vendor 0x0001, type 0 always hits, whatever the table holds, including when it is empty.
- R9: task_accept is 1 only when q_hit is 1, task_req_bytes is a multiple of 4 and task_rsp_bytes is at least 4.
- R10: start is ignored while a walk is in progress. A start after done or error clears the table (entry_count returns to 0) before the new walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an enumeration |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk finished cleanly |
| error | output | 1 | Walk stopped on a failure |
| entry_count | output | $clog2(DEPTH+1) | Number of table entries stored |
| abort_req | output | 1 | Ask the engine to abort the mailbox |
| abort_done | input | 1 | Engine has finished the abort |
| abort_ok | input | 1 | Abort left the mailbox idle and error-free |
| req_valid | output | 1 | Discovery request available |
| req_ready | input | 1 | Engine takes the request |
| req_vid | output | 16 | Request vendor ID |
| req_type | output | 8 | Request object type |
| req_payload | output | 32 | Request payload dword (index in [7:0]) |
| req_len_dw | output | LEN_W | Request payload length in dwords |
| rsp_valid | input | 1 | Exchange finished |
| rsp_ok | input | 1 | Exchange finished without fault |
| rsp_len_dw | input | LEN_W | Response payload length in dwords |
| rsp_data | input | 32 | First response payload dword |
| q_vid | input | 16 | Query vendor ID |
| q_type | input | 8 | Query protocol type |
| q_hit | output | 1 | Queried pair is supported |
| task_req_bytes | input | BYTES_W | Task request payload size in bytes |
| task_rsp_bytes | input | BYTES_W | Task response buffer size in bytes |
| task_accept | output | 1 | Task may be sent |

## Verification
A wrong index register shows up in the very next request payload, one cycle after the response that carried it. A slip in the slot counter shows up right away on entry_count, and also as a hit or miss for a known pair on the combinational query port. A state machine that misses a stop condition shows a stray req_valid, or a missing error, one cycle after the faulty response, the failed abort or the overflow. Each of these faults is visible at the ports within two cycles of its cause.

// File: rtl/proto_enum_pkg.sv
package proto_enum_pkg;

    localparam int VID_W   = 16;
    localparam int TYPE_W  = 8;
    localparam int IDX_W   = 8;
    localparam int DWORD_W = 32;

    localparam logic [VID_W-1:0]  DISC_VID  = 16'h0001;
    localparam logic [TYPE_W-1:0] DISC_TYPE = 8'h00;

    typedef struct packed {
        logic [VID_W-1:0]  vid;
        logic [TYPE_W-1:0] ptype;
    } proto_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ABORT,
        ST_REQ,
        ST_WAIT,
        ST_DONE,
        ST_FAIL
    } seq_state_e;

endpackage

// File: rtl/proto_enum_table.sv
module proto_enum_table
    import proto_enum_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  proto_t           wr_entry,
    input  proto_t           query,
    output logic             tbl_hit,
    output logic             full,
    output logic [CNT_W-1:0] count
);

    typedef struct packed {
        proto_t [DEPTH-1:0] ents;
        logic   [CNT_W-1:0] cnt;
    } tbl_t;

    tbl_t tbl_d, tbl_q;
    logic [DEPTH-1:0] match;

    assign full  = (tbl_q.cnt == CNT_W'(DEPTH));
    assign count = tbl_q.cnt;

    always_comb begin
        tbl_d = tbl_q;
        if (clr) begin
            tbl_d.cnt = '0;
        end else if (wr_en && !full) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CNT_W'(i) == tbl_q.cnt) begin
                    tbl_d.ents[i] = wr_entry;
                end
            end
            tbl_d.cnt = tbl_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
            assign match[g] = (CNT_W'(g) < tbl_q.cnt) && (tbl_q.ents[g] == query);
        end
    endgenerate

    assign tbl_hit = |match;

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full);

    // R10
    clear_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

endmodule

// File: rtl/proto_enum_gate.sv
module proto_enum_gate
    import proto_enum_pkg::*;
#(
    parameter int BYTES_W = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  proto_t             query,
    input  logic               tbl_hit,
    input  logic [BYTES_W-1:0] req_bytes,
    input  logic [BYTES_W-1:0] rsp_bytes,
    output logic               hit,
    output logic               accept
);

    logic is_disc;
    logic sizes_ok;

    assign is_disc  = (query.vid == DISC_VID) && (query.ptype == DISC_TYPE);
    assign hit      = is_disc || tbl_hit;
    assign sizes_ok = (req_bytes[1:0] == 2'b00) && (rsp_bytes >= BYTES_W'(4));
    assign accept   = hit && sizes_ok;

    // R8
    disc_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((query.vid == DISC_VID) && (query.ptype == DISC_TYPE)) |-> hit);

    // R9
    small_rsp_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_bytes < BYTES_W'(4)) |-> !accept);

endmodule

// File: rtl/proto_enum_seq.sv
module proto_enum_seq
    import proto_enum_pkg::*;
#(
    parameter int LEN_W = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               abort_done,
    input  logic               abort_ok,
    input  logic               req_ready,
    input  logic               rsp_valid,
    input  logic               rsp_ok,
    input  logic [LEN_W-1:0]   rsp_len_dw,
    input  logic [DWORD_W-1:0] rsp_data,
    input  logic               tbl_full,
    output logic               busy,
    output logic               done,
    output logic               error,
    output logic               abort_req,
    output logic               req_valid,
    output logic [DWORD_W-1:0] req_payload,
    output logic               tbl_clr,
    output logic               tbl_wr,
    output proto_t             tbl_entry
);

    typedef struct packed {
        seq_state_e        state;
        logic [IDX_W-1:0]  idx;
    } seq_t;

    seq_t seq_d, seq_q;
    logic             rsp_good;
    logic [IDX_W-1:0] next_idx;

    assign rsp_good  = rsp_ok && (rsp_len_dw == LEN_W'(1));
    assign next_idx  = rsp_data[31:24];
    assign tbl_entry = '{vid: rsp_data[15:0], ptype: rsp_data[23:16]};

    always_comb begin
        seq_d   = seq_q;
        tbl_clr = 1'b0;
        tbl_wr  = 1'b0;
        unique case (seq_q.state)
            ST_IDLE, ST_DONE, ST_FAIL: begin
                if (start) begin
                    seq_d.state = ST_ABORT;
                    tbl_clr     = 1'b1;
                end
            end
            ST_ABORT: begin
                if (abort_done) begin
                    seq_d.idx   = '0;
                    seq_d.state = abort_ok ? ST_REQ : ST_FAIL;
                end
            end
            ST_REQ: begin
                if (req_ready) begin
                    seq_d.state = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    if (!rsp_good || tbl_full) begin
                        seq_d.state = ST_FAIL;
                    end else begin
                        tbl_wr      = 1'b1;
                        seq_d.idx   = next_idx;
                        seq_d.state = (next_idx == '0) ? ST_DONE : ST_REQ;
                    end
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, idx: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign abort_req   = (seq_q.state == ST_ABORT);
    assign req_valid   = (seq_q.state == ST_REQ);
    assign busy        = abort_req || req_valid || (seq_q.state == ST_WAIT);
    assign done        = (seq_q.state == ST_DONE);
    assign error       = (seq_q.state == ST_FAIL);
    assign req_payload = {{(DWORD_W-IDX_W){1'b0}}, seq_q.idx};

    // R2
    abort_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_req && abort_done && !abort_ok) |=> (error && !req_valid));

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_payload)));

    // R4
    chain_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((seq_q.state == ST_WAIT) && rsp_valid && rsp_ok && (rsp_len_dw == LEN_W'(1))
         && (rsp_data[31:24] == 8'h00) && !tbl_full) |=> done);

    // R4
    next_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((seq_q.state == ST_WAIT) && rsp_valid && rsp_ok && (rsp_len_dw == LEN_W'(1))
         && (rsp_data[31:24] != 8'h00) && !tbl_full)
        |=> (req_valid && (req_payload[7:0] == $past(rsp_data[31:24]))));

    // R6
    bad_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((seq_q.state == ST_WAIT) && rsp_valid && (!rsp_ok || (rsp_len_dw != LEN_W'(1))))
        |=> (error && !req_valid));

    // R6
    error_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (error && !start) |=> error);

endmodule

// File: rtl/proto_enum.sv
module proto_enum
    import proto_enum_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int LEN_W   = 18,
    parameter int BYTES_W = 20
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    output logic                         busy,
    output logic                         done,
    output logic                         error,
    output logic [$clog2(DEPTH+1)-1:0]   entry_count,
    output logic                         abort_req,
    input  logic                         abort_done,
    input  logic                         abort_ok,
    output logic                         req_valid,
    input  logic                         req_ready,
    output logic [15:0]                  req_vid,
    output logic [7:0]                   req_type,
    output logic [31:0]                  req_payload,
    output logic [LEN_W-1:0]             req_len_dw,
    input  logic                         rsp_valid,
    input  logic                         rsp_ok,
    input  logic [LEN_W-1:0]             rsp_len_dw,
    input  logic [31:0]                  rsp_data,
    input  logic [15:0]                  q_vid,
    input  logic [7:0]                   q_type,
    output logic                         q_hit,
    input  logic [BYTES_W-1:0]           task_req_bytes,
    input  logic [BYTES_W-1:0]           task_rsp_bytes,
    output logic                         task_accept
);

    proto_t query;
    proto_t tbl_entry;
    logic   tbl_clr, tbl_wr, tbl_full, tbl_hit;

    assign query      = '{vid: q_vid, ptype: q_type};
    assign req_vid    = DISC_VID;
    assign req_type   = DISC_TYPE;
    assign req_len_dw = LEN_W'(1);

    proto_enum_seq #(.LEN_W(LEN_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .abort_done  (abort_done),
        .abort_ok    (abort_ok),
        .req_ready   (req_ready),
        .rsp_valid   (rsp_valid),
        .rsp_ok      (rsp_ok),
        .rsp_len_dw  (rsp_len_dw),
        .rsp_data    (rsp_data),
        .tbl_full    (tbl_full),
        .busy        (busy),
        .done        (done),
        .error       (error),
        .abort_req   (abort_req),
        .req_valid   (req_valid),
        .req_payload (req_payload),
        .tbl_clr     (tbl_clr),
        .tbl_wr      (tbl_wr),
        .tbl_entry   (tbl_entry)
    );

    proto_enum_table #(.DEPTH(DEPTH)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (tbl_clr),
        .wr_en    (tbl_wr),
        .wr_entry (tbl_entry),
        .query    (query),
        .tbl_hit  (tbl_hit),
        .full     (tbl_full),
        .count    (entry_count)
    );

    proto_enum_gate #(.BYTES_W(BYTES_W)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .query     (query),
        .tbl_hit   (tbl_hit),
        .req_bytes (task_req_bytes),
        .rsp_bytes (task_rsp_bytes),
        .hit       (q_hit),
        .accept    (task_accept)
    );

endmodule

// File: tb/tb_proto_enum.sv
module tb_proto_enum;

    localparam int DEPTH   = 4;
    localparam int LEN_W   = 18;
    localparam int BYTES_W = 20;
    localparam int CNT_W   = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [15:0]        vid;
        logic [7:0]         ptype;
        logic [BYTES_W-1:0] rb;
        logic [BYTES_W-1:0] sb;
        logic               hit;
        logic               acc;
    } vec_t;

    // Table after the first walk: (1234,11) (abcd,22) (0001,01)
    localparam vec_t VECS [8] = '{
        '{16'h1234, 8'h11, 20'd8,  20'd4,  1'b1, 1'b1},
        '{16'hABCD, 8'h22, 20'd0,  20'd4,  1'b1, 1'b1},
        '{16'h0001, 8'h01, 20'd4,  20'd16, 1'b1, 1'b1},
        '{16'h0001, 8'h00, 20'd4,  20'd4,  1'b1, 1'b1},
        '{16'h1234, 8'h22, 20'd4,  20'd4,  1'b0, 1'b0},
        '{16'hABCD, 8'h22, 20'd6,  20'd4,  1'b1, 1'b0},
        '{16'h1234, 8'h11, 20'd4,  20'd3,  1'b1, 1'b0},
        '{16'h5555, 8'h00, 20'd4,  20'd4,  1'b0, 1'b0}
    };

    localparam logic [31:0] CHAIN   [3] = '{32'h03_11_1234, 32'h07_22_ABCD, 32'h00_01_0001};
    localparam logic [7:0]  EXP_IDX [3] = '{8'd0, 8'd3, 8'd7};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic busy, done, error;
    logic [CNT_W-1:0] entry_count;
    logic abort_req;
    logic abort_done = 1'b0;
    logic abort_ok = 1'b0;
    logic req_valid;
    logic req_ready = 1'b1;
    logic [15:0] req_vid;
    logic [7:0] req_type;
    logic [31:0] req_payload;
    logic [LEN_W-1:0] req_len_dw;
    logic rsp_valid = 1'b0;
    logic rsp_ok = 1'b0;
    logic [LEN_W-1:0] rsp_len_dw = '0;
    logic [31:0] rsp_data = '0;
    logic [15:0] q_vid = '0;
    logic [7:0] q_type = '0;
    logic q_hit;
    logic [BYTES_W-1:0] task_req_bytes = '0;
    logic [BYTES_W-1:0] task_rsp_bytes = '0;
    logic task_accept;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    proto_enum #(.DEPTH(DEPTH), .LEN_W(LEN_W), .BYTES_W(BYTES_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .error(error), .entry_count(entry_count), .abort_req(abort_req),
        .abort_done(abort_done), .abort_ok(abort_ok), .req_valid(req_valid),
        .req_ready(req_ready), .req_vid(req_vid), .req_type(req_type),
        .req_payload(req_payload), .req_len_dw(req_len_dw), .rsp_valid(rsp_valid),
        .rsp_ok(rsp_ok), .rsp_len_dw(rsp_len_dw), .rsp_data(rsp_data),
        .q_vid(q_vid), .q_type(q_type), .q_hit(q_hit),
        .task_req_bytes(task_req_bytes), .task_rsp_bytes(task_rsp_bytes),
        .task_accept(task_accept)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic start_enum(input logic ok);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R2 abort_req after start", 32'(abort_req), 1);
        chk("R10 table cleared on start", 32'(entry_count), 0);
        @(negedge clk);
        chk("R2 abort_req held", 32'(abort_req), 1);
        chk("R2 no request during abort", 32'(req_valid), 0);
        abort_done = 1'b1; abort_ok = ok;
        @(negedge clk); abort_done = 1'b0;
    endtask

    task automatic get_req(input logic [7:0] exp_idx);
        int n = 0;
        while (!req_valid && n < 50) begin @(negedge clk); n++; end
        chk("R3 req_valid", 32'(req_valid), 1);
        chk("R3 req_vid", 32'(req_vid), 32'h1);
        chk("R3 req_type", 32'(req_type), 0);
        chk("R3 req_len_dw", 32'(req_len_dw), 1);
        chk("R4 req_payload index", req_payload, {24'h0, exp_idx});
    endtask

    task automatic send_rsp(input logic [31:0] word, input logic ok, input logic [LEN_W-1:0] len);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_data = word; rsp_ok = ok; rsp_len_dw = len;
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    task automatic look(input string tag, input logic [15:0] v, input logic [7:0] t,
                        input logic exp_hit);
        q_vid = v; q_type = t; task_req_bytes = 20'd4; task_rsp_bytes = 20'd4;
        #1;
        chk(tag, 32'(q_hit), 32'(exp_hit));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", 32'(busy), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 error", 32'(error), 0);
        chk("R1 abort_req", 32'(abort_req), 0);
        chk("R1 req_valid", 32'(req_valid), 0);
        chk("R1 entry_count", 32'(entry_count), 0);
        look("R8 discovery hits with empty table", 16'h0001, 8'h00, 1'b1);
        look("R5 empty table misses", 16'h1234, 8'h11, 1'b0);

        // Main walk of three entries, with request hold and ignored start
        req_ready = 1'b0;
        start_enum(1'b1);
        for (int k = 0; k < 3; k++) begin
            get_req(EXP_IDX[k]);
            if (k == 0) begin
                @(negedge clk);
                chk("R3 req held without ready", 32'(req_valid), 1);
                chk("R3 payload held without ready", req_payload, 0);
                req_ready = 1'b1;
            end
            if (k == 1) begin
                @(negedge clk); start = 1'b1;
                @(negedge clk); start = 1'b0;
                chk("R10 start ignored while busy: abort_req", 32'(abort_req), 0);
                chk("R10 start ignored while busy: busy", 32'(busy), 1);
                chk("R10 start ignored while busy: count", 32'(entry_count), 1);
            end
            send_rsp(CHAIN[k], 1'b1, 18'd1);
        end
        chk("R4 done after next index 0", 32'(done), 1);
        chk("R4 busy cleared", 32'(busy), 0);
        chk("R4 no error", 32'(error), 0);
        chk("R5 entry_count", 32'(entry_count), 3);

        // R5 R8 R9 lookup and task screening vectors
        foreach (VECS[i]) begin
            q_vid = VECS[i].vid; q_type = VECS[i].ptype;
            task_req_bytes = VECS[i].rb; task_rsp_bytes = VECS[i].sb;
            #1;
            chk($sformatf("R5 q_hit vector %0d", i), 32'(q_hit), 32'(VECS[i].hit));
            chk($sformatf("R9 task_accept vector %0d", i), 32'(task_accept), 32'(VECS[i].acc));
        end

        // R6 exchange fault
        start_enum(1'b1);
        get_req(8'd0);
        send_rsp(32'h05_11_1234, 1'b0, 18'd1);
        chk("R6 error on failed exchange", 32'(error), 1);
        chk("R6 not done", 32'(done), 0);
        chk("R6 nothing stored", 32'(entry_count), 0);
        repeat (3) begin
            @(negedge clk);
            chk("R6 no request after error", 32'(req_valid), 0);
            chk("R6 error sticky", 32'(error), 1);
        end

        // R6 wrong response length
        start_enum(1'b1);
        get_req(8'd0);
        send_rsp(32'h05_11_1234, 1'b1, 18'd2);
        chk("R6 error on length 2", 32'(error), 1);
        chk("R6 length error stores nothing", 32'(entry_count), 0);
        @(negedge clk);
        chk("R6 no request after length error", 32'(req_valid), 0);

        // R7 table overflow with DEPTH = 4
        start_enum(1'b1);
        for (int k = 0; k < 5; k++) begin
            get_req(8'(k));
            send_rsp({8'(k + 1), 8'(k + 2), 16'h4000 + 16'(k)}, 1'b1, 18'd1);
        end
        chk("R7 error on overflow", 32'(error), 1);
        chk("R7 count stays at depth", 32'(entry_count), DEPTH);
        look("R5 last slot stored", 16'h4003, 8'h05, 1'b1);
        look("R7 overflow pair not stored", 16'h4004, 8'h06, 1'b0);
        @(negedge clk);
        chk("R7 no request after overflow", 32'(req_valid), 0);

        // R2 abort failure
        start_enum(1'b0);
        chk("R2 error on abort failure", 32'(error), 1);
        chk("R2 no request after abort failure", 32'(req_valid), 0);
        chk("R10 table cleared by restart", 32'(entry_count), 0);
        look("R10 old entry gone", 16'h4000, 8'h02, 1'b0);
        look("R8 discovery still hits", 16'h0001, 8'h00, 1'b1);

        // R4 single-entry walk after an error
        start_enum(1'b1);
        get_req(8'd0);
        send_rsp(32'h00_44_9999, 1'b1, 18'd1);
        chk("R4 done after single entry", 32'(done), 1);
        chk("R4 error cleared by restart", 32'(error), 0);
        chk("R5 single entry counted", 32'(entry_count), 1);
        look("R5 single entry hits", 16'h9999, 8'h44, 1'b1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule